// File: doc/BRIEF.md
# Block Security Configuration Register Bank

This block is the software-visible side of a block-granular memory security controller. Memory behind the controller is divided into equal blocks. Each block has one bit in a table of 32-bit words. The bit says whether the block belongs to the non-secure world (1) or the secure world (0). A separate transaction filter reads the table bits, two control bits and the interrupt enable from this bank. When the filter blocks an access, it reports the event back to this bank.

Software reaches the bank over a simple 32-bit register bus. The bus carries byte lanes and a security attribute, and every access completes in the cycle it is presented. The table is not mapped word by word. Software selects a word with a pointer register and then reads or writes it through a single window register. After each full-word window access, the pointer can step forward on its own and wraps at the end of the table. Setting a seal bit freezes the control register, the table and the interrupt enable until the next reset. Non-secure software sees only a small identification window at the top of the space.

Top module: `blkprot_cfg_bank`

Register offsets are word addresses in a 4 KiB space:

| Offset | Name | Access |
|---|---|---|
| 0x00 | CTRL: bit 4 error-response select, bit 8 auto-step, bit 31 seal | read/write |
| 0x10 | WORDS: table word count minus one | read |
| 0x14 | GEOM: log2(block bytes) minus 5 | read |
| 0x18 | PTR: table word pointer | read/write |
| 0x1C | WIN: table word selected by PTR | read/write |
| 0x20 | ISTAT: bit 0 pending | read |
| 0x24 | ICLR: bit 0 clears pending | write, reads 0 |
| 0x28 | IEN: bit 0 enable | read/write |
| 0x2C | FADDR: captured fault address | read |
| 0x30 | FINFO: bits 15:0 master, bit 16 non-secure, bit 17 block bit | read |
| 0x34 | ISET: bit 0 sets pending | write, reads 0 |
| 0xFD0-0xFFC | ID window: twelve words, each holding one ID byte in bits 7:0 | read |

The seal logic is a two-state machine. `SEAL_OPEN` is entered at reset. The transition *seal* moves it to `SEAL_SHUT` when an accepted CTRL write carries bit 31 set. `SEAL_SHUT` has only the *hold* transition back to itself, so reset is the only way out.

## Requirements
- R1: After reset, CTRL reads 0x00000100, IEN reads 1, and PTR, ISTAT, FADDR, FINFO and every table word read 0. The irq, seal and error-response outputs are 0.
- R2: CTRL keeps only bit 4 (error-response select), bit 8 (auto-step) and bit 31 (seal). Every other CTRL bit reads 0 whatever was written.
- R3: A read with the security attribute low at any offset below 0xFD0 returns 0. A write with the attribute low at such an offset changes no register and does not move PTR.
- R4: Once CTRL bit 31 has been written as 1, writes to CTRL, WIN and IEN are ignored until reset. A rejected WIN write does not move PTR. PTR writes, WIN reads and interrupt set/clear still work.
- R5: WIN reads and writes the table word at PTR. When a WIN access has all four byte lanes on and auto-step is 1, PTR then becomes PTR+1, wrapping from the last word to 0. A WIN access with fewer lanes, or with auto-step 0, leaves PTR unchanged.
- R6: A PTR write stores the written 32-bit value modulo the table word count.
- R7: WORDS reads the table word count minus one. GEOM reads the log2 of the block size in bytes minus 5.
- R8: A write with some byte lanes off keeps the unwritten bytes' old contents for CTRL, PTR and WIN. For every other register the unwritten bytes are taken as zero.
- R9: Writing ISET with bit 0 at 1 sets the pending flag. Writing ICLR with bit 0 at 1 clears it, and a write with bit 0 at 0 has no effect. irq equals pending AND enable. ISET and ICLR read as 0.
- R10: A filter event while nothing is pending sets the pending flag. It also captures the event address into FADDR and {block bit, non-secure, master[15:0]} into FINFO bits 17:0. Events that arrive while the flag is already set leave FADDR and FINFO unchanged.
- R11: Bit b of table word w drives lut_bits[w*32+b]. The control outputs follow CTRL bits 4, 8 and 31, and irq_en follows IEN.
- R12: Offset 0xFD0+4*i (i = 0..11) reads ID_BYTES[8*i+7:8*i] in bits 7:0 for either security attribute, and writes there are ignored. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset (bits 1:0 ignored) |
| bus_be | input | 4 | Byte lanes of the access |
| bus_wdata | input | 32 | Write data |
| bus_secure | input | 1 | Security attribute of the access, 1 = secure |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| flt_evt | input | 1 | One-cycle pulse: filter blocked a transaction |
| flt_addr | input | 32 | Address of the blocked transaction |
| flt_master | input | 16 | Requester identity of the blocked transaction |
| flt_nonsec | input | 1 | Blocked transaction was non-secure |
| flt_cfgns | input | 1 | Table bit of the blocked address |
| lut_bits | output | WORDS*32 | Flattened block table |
| ctl_err_resp | output | 1 | Blocked accesses receive a bus error |
| ctl_autoinc | output | 1 | Auto-step enabled |
| ctl_sealed | output | 1 | Seal in force |
| irq_en | output | 1 | Interrupt enable |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets the pointer corners. It wraps PTR from the last word to zero, it tries sub-word and auto-step-off WIN accesses that must not advance it, and it writes PTR values beyond the table. An off-by-one wrap or a stepping sub-word access would leave later WIN reads returning the wrong word. It checks byte-lane merging against zero-filling with an IEN write whose enable byte is off and a PTR write whose low byte is off. A design that chose the wrong policy would clear PTR or keep IEN. It also runs seal attempts, non-secure probes and repeated filter events. A leaky design would let a frozen register change, expose secure state at offsets below 0xFD0, or overwrite the first captured fault.

// File: rtl/blkprot_cfg_pkg.sv
package blkprot_cfg_pkg;

    // Word offsets (byte offset / 4)
    localparam logic [9:0] W_CTRL  = 10'h000;
    localparam logic [9:0] W_WORDS = 10'h004;
    localparam logic [9:0] W_GEOM  = 10'h005;
    localparam logic [9:0] W_PTR   = 10'h006;
    localparam logic [9:0] W_WIN   = 10'h007;
    localparam logic [9:0] W_ISTAT = 10'h008;
    localparam logic [9:0] W_ICLR  = 10'h009;
    localparam logic [9:0] W_IEN   = 10'h00A;
    localparam logic [9:0] W_FADDR = 10'h00B;
    localparam logic [9:0] W_FINFO = 10'h00C;
    localparam logic [9:0] W_ISET  = 10'h00D;
    localparam logic [9:0] W_IDLO  = 10'h3F4;
    localparam int         ID_COUNT = 12;

    localparam int CTL_ERR_BIT  = 4;
    localparam int CTL_STEP_BIT = 8;
    localparam int CTL_SEAL_BIT = 31;

    typedef enum logic {
        SEAL_OPEN,
        SEAL_SHUT
    } seal_state_e;

    function automatic logic [31:0] lane_mask(input logic [3:0] be);
        logic [31:0] m;
        for (int i = 0; i < 4; i++) begin
            m[i*8 +: 8] = {8{be[i]}};
        end
        return m;
    endfunction

    function automatic logic [31:0] lane_merge(input logic [31:0] old_v,
                                               input logic [31:0] new_v,
                                               input logic [31:0] m);
        return (old_v & ~m) | (new_v & m);
    endfunction

endpackage

// File: rtl/blkprot_seal_fsm.sv
module blkprot_seal_fsm
    import blkprot_cfg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic seal_req,
    output logic sealed
);

    seal_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEAL_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEAL_OPEN: if (seal_req) state_d = SEAL_SHUT;
            SEAL_SHUT: state_d = SEAL_SHUT;
        endcase
    end

    always_comb begin
        unique case (state_q)
            SEAL_OPEN: sealed = 1'b0;
            SEAL_SHUT: sealed = 1'b1;
        endcase
    end

    // R4
    seal_enters_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seal_req |=> sealed);

    // R4
    seal_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sealed |=> sealed);

endmodule

// File: rtl/blkprot_lut_store.sv
module blkprot_lut_store #(
    parameter  int WORDS = 4,
    localparam int PTR_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  word_we,
    input  logic [31:0]           word_d,
    input  logic                  ptr_we,
    input  logic [31:0]           ptr_d,
    input  logic                  adv,
    output logic [31:0]           cur_word,
    output logic [PTR_W-1:0]      ptr,
    output logic [WORDS*32-1:0]   flat
);

    localparam logic [31:0]      WORDS_U = 32'(WORDS);
    localparam logic [PTR_W-1:0] LAST    = PTR_W'(WORDS - 1);

    logic [31:0] words_q [WORDS];
    logic [31:0] ptr_mod;

    assign ptr_mod = ptr_d % WORDS_U;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (ptr_we) begin
            ptr <= ptr_mod[PTR_W-1:0];
        end else if (adv) begin
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    end

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n)                               words_q[g] <= '0;
            else if (word_we && ptr == PTR_W'(g))     words_q[g] <= word_d;
        end
        assign flat[g*32 +: 32] = words_q[g];
    end

    assign cur_word = words_q[ptr];

    // R5
    ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(ptr) < WORDS_U);

    // R5
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !ptr_we && ptr == LAST) |=> ptr == '0);

endmodule

// File: rtl/blkprot_irq_unit.sv
module blkprot_irq_unit (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en_we,
    input  logic        en_d,
    input  logic        set_req,
    input  logic        clr_req,
    input  logic        evt,
    input  logic [31:0] evt_addr,
    input  logic [15:0] evt_master,
    input  logic        evt_nonsec,
    input  logic        evt_cfgns,
    output logic        stat,
    output logic        en,
    output logic        irq,
    output logic [31:0] faddr,
    output logic [31:0] finfo
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat  <= 1'b0;
            en    <= 1'b1;
            faddr <= '0;
            finfo <= '0;
        end else begin
            if (evt || set_req) stat <= 1'b1;
            else if (clr_req)   stat <= 1'b0;
            if (en_we) en <= en_d;
            if (evt && !stat) begin
                faddr <= evt_addr;
                finfo <= {14'd0, evt_cfgns, evt_nonsec, evt_master};
            end
        end
    end

    assign irq = stat & en;

    // R9
    set_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_req |=> stat);

    // R9
    clr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !set_req && !evt) |=> !stat);

    // R10
    info_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat |=> ($stable(faddr) && $stable(finfo)));

    // R10
    info_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && !stat) |=> (faddr == $past(evt_addr) && stat));

endmodule

// File: rtl/blkprot_cfg_bank.sv
module blkprot_cfg_bank
    import blkprot_cfg_pkg::*;
#(
    parameter int          WORDS    = 4,
    parameter int          BLK_LOG2 = 12,
    parameter logic [95:0] ID_BYTES = 96'hC3B2A1F0_5E4D3C2B_1A090807
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [11:0]         bus_addr,
    input  logic [3:0]          bus_be,
    input  logic [31:0]         bus_wdata,
    input  logic                bus_secure,
    output logic [31:0]         bus_rdata,
    input  logic                flt_evt,
    input  logic [31:0]         flt_addr,
    input  logic [15:0]         flt_master,
    input  logic                flt_nonsec,
    input  logic                flt_cfgns,
    output logic [WORDS*32-1:0] lut_bits,
    output logic                ctl_err_resp,
    output logic                ctl_autoinc,
    output logic                ctl_sealed,
    output logic                irq_en,
    output logic                irq
);

    localparam int          PTR_W      = (WORDS > 1) ? $clog2(WORDS) : 1;
    localparam logic [31:0] WORDS_RD   = 32'(WORDS - 1);
    localparam logic [31:0] GEOM_RD    = 32'(BLK_LOG2 - 5);
    localparam logic [11:0] NS_FLOOR   = 12'hFD0;

    logic [9:0]       waddr;
    logic             sec_ok, acc_we, acc_re;
    logic [31:0]      mask, zf;
    logic [31:0]      ctrl_word, ctrl_new, ptr_word, cur_word;
    logic             err_q, step_q;
    logic             ctrl_we, seal_req, ptr_we, win_we, win_re, adv;
    logic             en_we, set_req, clr_req;
    logic [PTR_W-1:0] ptr;
    logic             stat;
    logic [31:0]      faddr, finfo;

    assign waddr  = bus_addr[11:2];
    assign sec_ok = bus_secure || (bus_addr >= NS_FLOOR);
    assign acc_we = bus_sel && sec_ok && bus_wr;
    assign acc_re = bus_sel && sec_ok && !bus_wr;
    assign mask   = lane_mask(bus_be);
    assign zf     = bus_wdata & mask;

    assign ctrl_word = {ctl_sealed, 22'd0, step_q, 3'd0, err_q, 4'd0};
    assign ctrl_new  = lane_merge(ctrl_word, bus_wdata, mask);
    assign ptr_word  = 32'(ptr);

    assign ctrl_we  = acc_we && waddr == W_CTRL && !ctl_sealed;
    assign seal_req = ctrl_we && ctrl_new[CTL_SEAL_BIT];
    assign ptr_we   = acc_we && waddr == W_PTR;
    assign win_we   = acc_we && waddr == W_WIN && !ctl_sealed;
    assign win_re   = acc_re && waddr == W_WIN;
    assign adv      = (win_we || win_re) && bus_be == 4'hF && step_q;
    assign en_we    = acc_we && waddr == W_IEN && !ctl_sealed;
    assign set_req  = acc_we && waddr == W_ISET && zf[0];
    assign clr_req  = acc_we && waddr == W_ICLR && zf[0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q  <= 1'b0;
            step_q <= 1'b1;
        end else if (ctrl_we) begin
            err_q  <= ctrl_new[CTL_ERR_BIT];
            step_q <= ctrl_new[CTL_STEP_BIT];
        end
    end

    blkprot_seal_fsm u_seal (
        .clk      (clk),
        .rst_n    (rst_n),
        .seal_req (seal_req),
        .sealed   (ctl_sealed)
    );

    blkprot_lut_store #(.WORDS(WORDS)) u_lut (
        .clk      (clk),
        .rst_n    (rst_n),
        .word_we  (win_we),
        .word_d   (lane_merge(cur_word, bus_wdata, mask)),
        .ptr_we   (ptr_we),
        .ptr_d    (lane_merge(ptr_word, bus_wdata, mask)),
        .adv      (adv),
        .cur_word (cur_word),
        .ptr      (ptr),
        .flat     (lut_bits)
    );

    blkprot_irq_unit u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_we      (en_we),
        .en_d       (zf[0]),
        .set_req    (set_req),
        .clr_req    (clr_req),
        .evt        (flt_evt),
        .evt_addr   (flt_addr),
        .evt_master (flt_master),
        .evt_nonsec (flt_nonsec),
        .evt_cfgns  (flt_cfgns),
        .stat       (stat),
        .en         (irq_en),
        .irq        (irq),
        .faddr      (faddr),
        .finfo      (finfo)
    );

    assign ctl_err_resp = err_q;
    assign ctl_autoinc  = step_q;

    always_comb begin
        bus_rdata = '0;
        if (acc_re) begin
            case (waddr)
                W_CTRL:  bus_rdata = ctrl_word;
                W_WORDS: bus_rdata = WORDS_RD;
                W_GEOM:  bus_rdata = GEOM_RD;
                W_PTR:   bus_rdata = ptr_word;
                W_WIN:   bus_rdata = cur_word;
                W_ISTAT: bus_rdata = {31'd0, stat};
                W_IEN:   bus_rdata = {31'd0, irq_en};
                W_FADDR: bus_rdata = faddr;
                W_FINFO: bus_rdata = finfo;
                default: bus_rdata = '0;
            endcase
            for (int i = 0; i < ID_COUNT; i++) begin
                if (waddr == W_IDLO + 10'(i)) bus_rdata = {24'd0, ID_BYTES[i*8 +: 8]};
            end
        end
    end

    // R3
    ns_write_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && !bus_secure && bus_addr < NS_FLOOR) |=>
        ($stable(lut_bits) && $stable(ctl_err_resp) && $stable(ctl_autoinc) &&
         $stable(irq_en) && $stable(ctl_sealed)));

    // R3
    ns_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && !bus_secure && bus_addr < NS_FLOOR) |-> bus_rdata == '0);

    // R4
    sealed_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_sealed |=> ($stable(lut_bits) && $stable(irq_en) &&
                        $stable(ctl_err_resp) && $stable(ctl_autoinc)));

endmodule

// File: tb/test_blkprot_cfg_bank.sv
`timescale 1ns/1ps
module test_blkprot_cfg_bank;

    localparam int          WORDS    = 4;
    localparam logic [95:0] ID_EXP   = 96'hC3B2A1F0_5E4D3C2B_1A090807;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_sel = 1'b0, bus_wr = 1'b0, bus_secure = 1'b1;
    logic [11:0]       bus_addr = '0;
    logic [3:0]        bus_be = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              flt_evt = 1'b0, flt_nonsec = 1'b0, flt_cfgns = 1'b0;
    logic [31:0]       flt_addr = '0;
    logic [15:0]       flt_master = '0;
    logic [WORDS*32-1:0] lut_bits;
    logic              ctl_err_resp, ctl_autoinc, ctl_sealed, irq_en, irq;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [31:0] v;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    blkprot_cfg_bank #(.WORDS(WORDS), .BLK_LOG2(12), .ID_BYTES(ID_EXP)) i_blkprot_cfg_bank (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_secure(bus_secure), .bus_rdata(bus_rdata), .flt_evt(flt_evt),
        .flt_addr(flt_addr), .flt_master(flt_master), .flt_nonsec(flt_nonsec),
        .flt_cfgns(flt_cfgns), .lut_bits(lut_bits), .ctl_err_resp(ctl_err_resp),
        .ctl_autoinc(ctl_autoinc), .ctl_sealed(ctl_sealed), .irq_en(irq_en), .irq(irq)
    );

    // Monitor: pops expected read data and compares near the end of the cycle
    initial begin
        forever begin
            @(negedge clk);
            #4;
            if (bus_sel && !bus_wr) begin
                checks++;
                if (sb.size() == 0) begin
                    errors++;
                    $display("FAIL scoreboard: unexpected read rdata=%h expected=none", bus_rdata);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    if (bus_rdata !== e.v) begin
                        errors++;
                        $display("FAIL %s: rdata=%h expected=%h", e.tag, bus_rdata, e.v);
                    end
                end
            end
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d,
                      input logic [3:0] be = 4'hF, input logic sec = 1'b1);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        bus_be = be; bus_secure = sec;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag,
                      input logic [3:0] be = 4'hF, input logic sec = 1'b1);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_wdata = '0;
        bus_be = be; bus_secure = sec;
        sb.push_back('{exp, tag});
    endtask

    task automatic idle();
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_secure = 1'b1; flt_evt = 1'b0;
    endtask

    task automatic pchk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic fault(input logic [31:0] a, input logic [15:0] m,
                         input logic ns, input logic cfg);
        @(negedge clk);
        bus_sel = 1'b0;
        flt_addr = a; flt_master = m; flt_nonsec = ns; flt_cfgns = cfg; flt_evt = 1'b1;
        @(negedge clk);
        flt_evt = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        bus_sel = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        do_reset();

        // R1 reset state
        rd(12'h000, 32'h0000_0100, "R1 ctrl reset");
        rd(12'h028, 32'h1, "R1 ien reset");
        rd(12'h018, 32'h0, "R1 ptr reset");
        rd(12'h020, 32'h0, "R1 istat reset");
        rd(12'h02C, 32'h0, "R1 faddr reset");
        rd(12'h030, 32'h0, "R1 finfo reset");
        rd(12'h01C, 32'h0, "R1 table word reset", 4'h1);
        rd(12'h018, 32'h0, "R5 sub-word read keeps ptr");
        idle();
        pchk({31'd0, irq}, 32'h0, "R1 irq reset");
        pchk({31'd0, ctl_sealed}, 32'h0, "R1 sealed reset");
        pchk({31'd0, ctl_err_resp}, 32'h0, "R1 err_resp reset");
        pchk(lut_bits[31:0] | lut_bits[63:32] | lut_bits[95:64] | lut_bits[127:96],
             32'h0, "R1 table reset");

        // R7 geometry
        rd(12'h010, 32'd3, "R7 word count minus one");
        rd(12'h014, 32'd7, "R7 block size code");

        // R2 ctrl reserved bits
        wr(12'h000, 32'h7FFF_FEFF);
        rd(12'h000, 32'h0000_0010, "R2 ctrl keeps bit4 only");
        idle();
        pchk({31'd0, ctl_err_resp}, 32'h1, "R11 err_resp output");
        pchk({31'd0, ctl_autoinc}, 32'h0, "R11 autoinc output");
        wr(12'h000, 32'h0000_0100);
        rd(12'h000, 32'h0000_0100, "R2 ctrl restore");

        // R5 auto-step and wrap
        wr(12'h018, 32'h0);
        wr(12'h01C, 32'hA5A5_0001);
        wr(12'h01C, 32'h0000_0002);
        wr(12'h01C, 32'h0000_0003);
        wr(12'h01C, 32'h8000_0004);
        rd(12'h018, 32'h0, "R5 ptr wrapped");
        rd(12'h01C, 32'hA5A5_0001, "R5 window word0");
        rd(12'h018, 32'h1, "R5 full read steps ptr");
        idle();
        pchk(lut_bits[31:0],   32'hA5A5_0001, "R11 lut word0");
        pchk(lut_bits[63:32],  32'h0000_0002, "R11 lut word1");
        pchk(lut_bits[95:64],  32'h0000_0003, "R11 lut word2");
        pchk(lut_bits[127:96], 32'h8000_0004, "R11 lut word3");
        wr(12'h000, 32'h0);
        wr(12'h01C, 32'h0000_1234);
        rd(12'h018, 32'h1, "R5 no step with autoinc off (write)");
        rd(12'h01C, 32'h0000_1234, "R5 window word1");
        rd(12'h018, 32'h1, "R5 no step with autoinc off (read)");
        wr(12'h000, 32'h0000_0100);

        // R6 ptr modulo
        wr(12'h018, 32'd6);
        rd(12'h018, 32'd2, "R6 ptr 6 mod 4");
        wr(12'h018, 32'hFFFF_FFFF);
        rd(12'h018, 32'd3, "R6 ptr max mod 4");

        // R8 sub-word merge vs zero fill
        wr(12'h018, 32'd2);
        wr(12'h01C, 32'h00AB_0000, 4'b0100);
        rd(12'h018, 32'd2, "R5 sub-word write keeps ptr");
        rd(12'h01C, 32'h00AB_0003, "R8 window byte merge", 4'h1);
        rd(12'h018, 32'd2, "R5 sub-word read keeps ptr");
        wr(12'h000, 32'h0000_0010, 4'b0001);
        rd(12'h000, 32'h0000_0110, "R8 ctrl byte merge");
        wr(12'h000, 32'h0000_0100);
        wr(12'h028, 32'h0000_0101, 4'b0010);
        rd(12'h028, 32'h0, "R8 ien zero fill");
        wr(12'h028, 32'h1);
        wr(12'h018, 32'h0000_0500, 4'b0010);
        rd(12'h018, 32'd2, "R8 ptr byte merge");

        // R9 interrupt set/clear
        rd(12'h020, 32'h0, "R9 istat idle");
        wr(12'h034, 32'h1);
        idle();
        pchk({31'd0, irq}, 32'h1, "R9 irq after set");
        rd(12'h034, 32'h0, "R9 iset reads zero");
        rd(12'h024, 32'h0, "R9 iclr reads zero");
        wr(12'h028, 32'h0);
        idle();
        pchk({31'd0, irq}, 32'h0, "R9 irq masked");
        pchk({31'd0, irq_en}, 32'h0, "R11 irq_en output");
        wr(12'h028, 32'h1);
        wr(12'h024, 32'h0000_0002);
        rd(12'h020, 32'h1, "R9 clear without bit0 ignored");
        wr(12'h024, 32'h1);
        idle();
        pchk({31'd0, irq}, 32'h0, "R9 irq after clear");
        rd(12'h020, 32'h0, "R9 istat cleared");

        // R10 fault capture
        fault(32'h0000_3000, 16'h0042, 1'b1, 1'b0);
        pchk({31'd0, irq}, 32'h1, "R10 event raises irq");
        rd(12'h02C, 32'h0000_3000, "R10 first fault addr");
        rd(12'h030, 32'h0001_0042, "R10 first fault info");
        fault(32'h0000_5000, 16'h0007, 1'b0, 1'b1);
        rd(12'h02C, 32'h0000_3000, "R10 second fault ignored addr");
        rd(12'h030, 32'h0001_0042, "R10 second fault ignored info");
        wr(12'h024, 32'h1);
        fault(32'h0000_7000, 16'hBEEF, 1'b0, 1'b1);
        rd(12'h02C, 32'h0000_7000, "R10 recapture addr");
        rd(12'h030, 32'h0002_BEEF, "R10 recapture info");
        wr(12'h024, 32'h1);

        // R3 non-secure gating
        rd(12'h000, 32'h0, "R3 ns ctrl read", 4'hF, 1'b0);
        wr(12'h000, 32'h8000_0010, 4'hF, 1'b0);
        rd(12'h000, 32'h0000_0100, "R3 ns ctrl write dropped");
        wr(12'h018, 32'h1, 4'hF, 1'b0);
        rd(12'h018, 32'd2, "R3 ns ptr write dropped");
        rd(12'h01C, 32'h0, "R3 ns window read", 4'hF, 1'b0);
        rd(12'h018, 32'd2, "R3 ns window read keeps ptr");
        wr(12'h034, 32'h1, 4'hF, 1'b0);
        idle();
        pchk({31'd0, irq}, 32'h0, "R3 ns iset dropped");
        rd(12'hFD0, {24'd0, ID_EXP[7:0]}, "R3 ns id read", 4'hF, 1'b0);

        // R12 id window and unmapped
        for (int i = 0; i < 12; i++) begin
            rd(12'hFD0 + 12'(4 * i), {24'd0, ID_EXP[i*8 +: 8]}, "R12 id byte");
        end
        wr(12'hFE0, 32'hFFFF_FFFF);
        rd(12'hFE0, {24'd0, ID_EXP[39:32]}, "R12 id write ignored");
        rd(12'h004, 32'h0, "R12 unmapped read");
        rd(12'h800, 32'h0, "R12 unmapped high read");

        // R4 seal
        wr(12'h000, 32'h8000_0100);
        idle();
        pchk({31'd0, ctl_sealed}, 32'h1, "R4 sealed output");
        rd(12'h000, 32'h8000_0100, "R4 ctrl sealed value");
        wr(12'h000, 32'h0);
        rd(12'h000, 32'h8000_0100, "R4 ctrl frozen");
        wr(12'h018, 32'h0);
        wr(12'h01C, 32'h0000_DEAD);
        rd(12'h018, 32'h0, "R4 rejected window write keeps ptr");
        rd(12'h01C, 32'hA5A5_0001, "R4 window frozen", 4'h1);
        wr(12'h028, 32'h0);
        rd(12'h028, 32'h1, "R4 ien frozen");
        wr(12'h018, 32'd3);
        rd(12'h018, 32'd3, "R4 ptr still writable");
        do_reset();
        rd(12'h000, 32'h0000_0100, "R4 reset leaves seal");
        idle();
        pchk({31'd0, ctl_sealed}, 32'h0, "R4 sealed cleared by reset");
        pchk(lut_bits[31:0], 32'h0, "R1 table cleared by reset");

        idle();
        idle();
        if (sb.size() != 0) begin
            errors++; checks++;
            $display("FAIL scoreboard: leftover=%0d expected=0", sb.size());
        end
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule